// File: doc/BRIEF.md
# Event-Driven Multi-Output PWM Timer

The block is a pulse-width timer built around one shared up-counter. A bank of match registers is compared against the counter. Each of several events is bound to one of those match registers and fires on the prescaled tick where the two are equal. Outputs are not wired to fixed compare channels. Every output has a set mask and a clear mask over the events. A limit mask names the events that restart the counter, so one period is shared by all outputs. When a set event and a clear event for the same output fire on the same tick, a per-output two-bit rule decides the outcome.

Software drives the block through a small synchronous word-addressed bus. The control word holds a halt bit and a clock prescaler. Every match register has a reload copy. The match takes the reload value only at a period boundary, or at any cycle while the timer is halted, so a new period or duty value never cuts a running period short. A typical setup gives one event the period match and lists it in the limit mask. A second event carries the duty match. Normal polarity sets the output on the period event and clears it on the duty event; inverted polarity swaps the two roles.

Top module: `evpwm_timer`

## Requirements
- R1: After reset all outputs are 0, the counter is 0 and frozen, the control word reads 0x4 (halt bit set, prescaler 0), and every mask, match and reload register reads 0.
- R2: An event fires on a tick only when bits 13:12 of its config word equal 1 and the match register chosen by the config word's low bits (bits 3:0 at default size) equals the counter. A config word of 0, or one with any other combine value, never fires.
- R3: When an event whose bit is set in the limit mask fires, the counter becomes 0 on that tick instead of incrementing. A limit match value M therefore gives a period of M+1 ticks.
- R4: Bit e of an output's set mask (or clear mask) selects event e. On a tick where a set event fires and no clear event fires, the output goes to 1. On a tick where a clear event fires and no set event fires, the output goes to 0. Without a tick the output holds its value.
- R5: Output o's conflict rule sits at bits 2o+1:2o of the conflict register: 0 keeps the value, 1 sets, 2 clears, 3 toggles. The rule applies when set and clear events for that output fire on the same tick.
- R6: In normal polarity with period N and duty match D < N-1, the output is high for D+1 of every N ticks. In inverted polarity it is high for N-1-D ticks. With D = N-1, normal polarity with rule set stays high, and inverted polarity with rule clear stays low.
- R7: A match register loads its reload value on a tick where a limit event fires, and on every cycle while the timer is halted. A reload write in mid-period leaves the active match unchanged until the boundary.
- R8: While control bit 2 (halt) is 1, the counter and all outputs hold their values.
- R9: The prescaler in control bits 12:5 makes the timer tick once every prescaler+1 clocks. A value of 0 ticks on every clock.
- R10: The word map is: 0x00 control, 0x01 limit mask, 0x02 conflict rules, 0x03 counter (read only), 0x10+i match i, 0x20+i reload i, 0x30+i event i config, 0x40+o set mask o, 0x50+o clear mask o. Written values read back. Read data appears on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Word address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| pwm_out | output | N_OUT (16) | Timer outputs |

## Verification
A wrong counter limit or prescaler shows at the ports within one period as a wrong count of rising edges or high samples in a window of four periods. A mask, conflict rule or polarity error shows as a wrong duty fraction in that same window. A corrupted match or reload value shows on the next read of that register, or after the next boundary as a wrong period. A halt that fails to freeze shows as a counter read that moves between two reads taken ten clocks apart.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;
   // conflict rule applied when set and clear meet on one tick
   typedef enum logic [1:0] {
      RULE_KEEP   = 2'd0,
      RULE_SET    = 2'd1,
      RULE_CLEAR  = 2'd2,
      RULE_TOGGLE = 2'd3
   } rule_t;

   localparam logic [1:0] COMB_MATCH = 2'd1;   // event uses match condition only
   localparam int HALT_BIT = 2;
   localparam int PRE_LSB  = 5;
   localparam int COMB_LSB = 12;

   // address pages (bus_addr[7:4]) and indices in page 0
   localparam logic [3:0] PG_MISC   = 4'h0;
   localparam logic [3:0] PG_MATCH  = 4'h1;
   localparam logic [3:0] PG_RELOAD = 4'h2;
   localparam logic [3:0] PG_EVCFG  = 4'h3;
   localparam logic [3:0] PG_SETM   = 4'h4;
   localparam logic [3:0] PG_CLRM   = 4'h5;
   localparam logic [3:0] IX_CTRL   = 4'h0;
   localparam logic [3:0] IX_LIMIT  = 4'h1;
   localparam logic [3:0] IX_CONF   = 4'h2;
   localparam logic [3:0] IX_COUNT  = 4'h3;
endpackage

// File: rtl/evpwm_regs.sv
module evpwm_regs
   import evpwm_pkg::*;
#(
   parameter int N_OUT   = 16,
   parameter int N_EV    = 16,
   parameter int N_MATCH = 16,
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   localparam int SEL_W  = $clog2(N_MATCH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic                              bus_wr,
   input  logic [DATA_W-1:0]                 bus_wdata,
   output logic [DATA_W-1:0]                 bus_rdata,
   input  logic [CNT_W-1:0]                  cnt_in,
   input  logic                              reload_go,
   output logic                              halt_o,
   output logic [PRE_W-1:0]                  pre_o,
   output logic [N_EV-1:0]                   limit_o,
   output logic [2*N_OUT-1:0]                conf_o,
   output logic [N_MATCH-1:0][CNT_W-1:0]     match_o,
   output logic [N_EV-1:0][SEL_W-1:0]        evsel_o,
   output logic [N_EV-1:0][1:0]              evcomb_o,
   output logic [N_OUT-1:0][N_EV-1:0]        setm_o,
   output logic [N_OUT-1:0][N_EV-1:0]        clrm_o
);
   logic [N_MATCH-1:0][CNT_W-1:0] reload_q;
   logic [DATA_W-1:0]             rd_c;
   logic                          hi_ok;
   logic [3:0]                    page, idx;

   assign page = bus_addr[7:4];
   assign idx  = bus_addr[3:0];

   generate
      if (ADDR_W > 8) begin : g_wide_addr
         assign hi_ok = ~|bus_addr[ADDR_W-1:8];
      end else begin : g_narrow_addr
         assign hi_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_o   <= 1'b1;
         pre_o    <= '0;
         limit_o  <= '0;
         conf_o   <= '0;
         match_o  <= '0;
         reload_q <= '0;
         evsel_o  <= '0;
         evcomb_o <= '0;
         setm_o   <= '0;
         clrm_o   <= '0;
      end else begin
         if (reload_go) match_o <= reload_q;
         if (bus_wr && hi_ok) begin
            case (page)
               PG_MISC: begin
                  if (idx == IX_CTRL) begin
                     halt_o <= bus_wdata[HALT_BIT];
                     pre_o  <= bus_wdata[PRE_LSB +: PRE_W];
                  end
                  if (idx == IX_LIMIT) limit_o <= bus_wdata[N_EV-1:0];
                  if (idx == IX_CONF)  conf_o  <= bus_wdata[2*N_OUT-1:0];
               end
               PG_MATCH:
                  for (int k = 0; k < N_MATCH; k++)
                     if (idx == 4'(k)) match_o[k] <= bus_wdata[CNT_W-1:0];
               PG_RELOAD:
                  for (int k = 0; k < N_MATCH; k++)
                     if (idx == 4'(k)) reload_q[k] <= bus_wdata[CNT_W-1:0];
               PG_EVCFG:
                  for (int k = 0; k < N_EV; k++)
                     if (idx == 4'(k)) begin
                        evsel_o[k]  <= bus_wdata[SEL_W-1:0];
                        evcomb_o[k] <= bus_wdata[COMB_LSB +: 2];
                     end
               PG_SETM:
                  for (int k = 0; k < N_OUT; k++)
                     if (idx == 4'(k)) setm_o[k] <= bus_wdata[N_EV-1:0];
               PG_CLRM:
                  for (int k = 0; k < N_OUT; k++)
                     if (idx == 4'(k)) clrm_o[k] <= bus_wdata[N_EV-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_c = '0;
      if (hi_ok) begin
         case (page)
            PG_MISC: begin
               if (idx == IX_CTRL) begin
                  rd_c[HALT_BIT]         = halt_o;
                  rd_c[PRE_LSB +: PRE_W] = pre_o;
               end
               if (idx == IX_LIMIT) rd_c[N_EV-1:0]    = limit_o;
               if (idx == IX_CONF)  rd_c[2*N_OUT-1:0] = conf_o;
               if (idx == IX_COUNT) rd_c[CNT_W-1:0]   = cnt_in;
            end
            PG_MATCH:
               for (int k = 0; k < N_MATCH; k++)
                  if (idx == 4'(k)) rd_c[CNT_W-1:0] = match_o[k];
            PG_RELOAD:
               for (int k = 0; k < N_MATCH; k++)
                  if (idx == 4'(k)) rd_c[CNT_W-1:0] = reload_q[k];
            PG_EVCFG:
               for (int k = 0; k < N_EV; k++)
                  if (idx == 4'(k)) begin
                     rd_c[SEL_W-1:0]     = evsel_o[k];
                     rd_c[COMB_LSB +: 2] = evcomb_o[k];
                  end
            PG_SETM:
               for (int k = 0; k < N_OUT; k++)
                  if (idx == 4'(k)) rd_c[N_EV-1:0] = setm_o[k];
            PG_CLRM:
               for (int k = 0; k < N_OUT; k++)
                  if (idx == 4'(k)) rd_c[N_EV-1:0] = clrm_o[k];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_c;
   end
endmodule

// File: rtl/evpwm_core.sv
module evpwm_core
   import evpwm_pkg::*;
#(
   parameter int N_EV    = 16,
   parameter int N_MATCH = 16,
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 8,
   localparam int SEL_W  = $clog2(N_MATCH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          halt,
   input  logic [PRE_W-1:0]              pre,
   input  logic [N_EV-1:0]               limit,
   input  logic [N_MATCH-1:0][CNT_W-1:0] match,
   input  logic [N_EV-1:0][SEL_W-1:0]    evsel,
   input  logic [N_EV-1:0][1:0]          evcomb,
   output logic [CNT_W-1:0]              cnt_q,
   output logic                          tick,
   output logic [N_EV-1:0]               ev_fire,
   output logic                          reload_go
);
   logic [PRE_W-1:0] pdiv_q;
   logic [N_EV-1:0]  ev_hit;
   logic             lim_hit;

   assign tick = !halt && (pdiv_q >= pre);

   always_ff @(posedge clk) begin
      if (!rst_n || halt || tick) pdiv_q <= '0;
      else                        pdiv_q <= pdiv_q + PRE_W'(1);
   end

   generate
      for (genvar e = 0; e < N_EV; e++) begin : g_ev
         assign ev_hit[e] = (evcomb[e] == COMB_MATCH) && (match[evsel[e]] == cnt_q);
      end
   endgenerate

   assign ev_fire   = tick ? ev_hit : '0;
   assign lim_hit   = |(ev_fire & limit);
   assign reload_go = halt || lim_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (lim_hit) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/evpwm_outcell.sv
module evpwm_outcell
   import evpwm_pkg::*;
#(
   parameter int N_EV = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_EV-1:0] fire,
   input  logic [N_EV-1:0] set_mask,
   input  logic [N_EV-1:0] clr_mask,
   input  logic [1:0]      rule,
   output logic            out_q
);
   logic do_set, do_clr;

   assign do_set = |(fire & set_mask);
   assign do_clr = |(fire & clr_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= 1'b0;
      else if (do_set && do_clr) begin
         case (rule_t'(rule))
            RULE_SET:    out_q <= 1'b1;
            RULE_CLEAR:  out_q <= 1'b0;
            RULE_TOGGLE: out_q <= ~out_q;
            default:     out_q <= out_q;
         endcase
      end
      else if (do_set) out_q <= 1'b1;
      else if (do_clr) out_q <= 1'b0;
   end
endmodule

// File: rtl/evpwm_timer.sv
module evpwm_timer
   import evpwm_pkg::*;
#(
   parameter int N_OUT   = 16,
   parameter int N_EV    = 16,
   parameter int N_MATCH = 16,
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_OUT-1:0]  pwm_out
);
   localparam int SEL_W = $clog2(N_MATCH);

   generate
      if (N_OUT < 1 || N_OUT > 16 || 2*N_OUT > DATA_W) begin : g_bad_out
         $error("N_OUT must be 1..16 and its rule fields must fit in DATA_W");
      end
      if (N_EV < 1 || N_EV > 16 || N_EV > DATA_W) begin : g_bad_ev
         $error("N_EV must be 1..16 and fit in DATA_W");
      end
      if (N_MATCH < 2 || N_MATCH > 16 || (1 << SEL_W) != N_MATCH) begin : g_bad_match
         $error("N_MATCH must be a power of two from 2 to 16");
      end
      if (CNT_W > DATA_W || PRE_LSB + PRE_W > DATA_W || COMB_LSB + 2 > DATA_W) begin : g_bad_data
         $error("DATA_W too narrow for counter, prescaler or event config");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
   endgenerate

   logic                          halt_q;
   logic [PRE_W-1:0]              pre_q;
   logic [N_EV-1:0]               limit_q;
   logic [2*N_OUT-1:0]            conf_q;
   logic [N_MATCH-1:0][CNT_W-1:0] match_q;
   logic [N_EV-1:0][SEL_W-1:0]    evsel_q;
   logic [N_EV-1:0][1:0]          evcomb_q;
   logic [N_OUT-1:0][N_EV-1:0]    setm_q;
   logic [N_OUT-1:0][N_EV-1:0]    clrm_q;
   logic [CNT_W-1:0]              cnt_q;
   logic                          tick;
   logic [N_EV-1:0]               ev_fire;
   logic                          reload_go;

   evpwm_regs #(
      .N_OUT(N_OUT), .N_EV(N_EV), .N_MATCH(N_MATCH), .CNT_W(CNT_W),
      .PRE_W(PRE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_q),
      .reload_go(reload_go), .halt_o(halt_q), .pre_o(pre_q),
      .limit_o(limit_q), .conf_o(conf_q), .match_o(match_q),
      .evsel_o(evsel_q), .evcomb_o(evcomb_q), .setm_o(setm_q), .clrm_o(clrm_q)
   );

   evpwm_core #(
      .N_EV(N_EV), .N_MATCH(N_MATCH), .CNT_W(CNT_W), .PRE_W(PRE_W)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .halt(halt_q), .pre(pre_q), .limit(limit_q),
      .match(match_q), .evsel(evsel_q), .evcomb(evcomb_q), .cnt_q(cnt_q),
      .tick(tick), .ev_fire(ev_fire), .reload_go(reload_go)
   );

   generate
      for (genvar o = 0; o < N_OUT; o++) begin : g_out
         evpwm_outcell #(.N_EV(N_EV)) u_cell (
            .clk(clk), .rst_n(rst_n), .fire(ev_fire),
            .set_mask(setm_q[o]), .clr_mask(clrm_q[o]),
            .rule(conf_q[2*o +: 2]), .out_q(pwm_out[o])
         );
      end
   endgenerate
endmodule

// File: rtl/evpwm_checker.sv
module evpwm_checker #(
   parameter int N_OUT = 16,
   parameter int N_EV  = 16,
   parameter int CNT_W = 32,
   parameter int PRE_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       halt,
   input logic [PRE_W-1:0]           pre,
   input logic                       bus_wr,
   input logic                       tick,
   input logic [N_EV-1:0]            fire,
   input logic [N_EV-1:0]            limit,
   input logic [CNT_W-1:0]           cnt,
   input logic [N_OUT-1:0][N_EV-1:0] setm,
   input logic [N_OUT-1:0][N_EV-1:0] clrm,
   input logic [2*N_OUT-1:0]         conf,
   input logic [N_OUT-1:0]           pwm_out
);
   assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> ($stable(cnt) && $stable(pwm_out)));

   assert_limit_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && |(fire & limit)) |=> (cnt == '0));

   assert_prescale_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pre != '0 && !bus_wr) |=> !tick);

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pwm_out));

   generate
      for (genvar o = 0; o < N_OUT; o++) begin : g_chk
         assert_set_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (|(fire & setm[o]) && !(|(fire & clrm[o]))) |=> pwm_out[o]);
         assert_clr_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (|(fire & clrm[o]) && !(|(fire & setm[o]))) |=> !pwm_out[o]);
         assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (|(fire & setm[o]) && |(fire & clrm[o]) && conf[2*o +: 2] == 2'd3)
            |=> (pwm_out[o] != $past(pwm_out[o])));
      end
   endgenerate
endmodule

bind evpwm_timer evpwm_checker #(
   .N_OUT(N_OUT), .N_EV(N_EV), .CNT_W(CNT_W), .PRE_W(PRE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .halt(halt_q), .pre(pre_q), .bus_wr(bus_wr),
   .tick(tick), .fire(ev_fire), .limit(limit_q), .cnt(cnt_q),
   .setm(setm_q), .clrm(clrm_q), .conf(conf_q), .pwm_out(pwm_out)
);

// File: tb/sim_evpwm_timer.sv
`timescale 1ns/1ps
module sim_evpwm_timer;
   localparam logic [7:0] A_CTRL = 8'h00, A_LIMIT = 8'h01, A_CONF = 8'h02, A_COUNT = 8'h03;
   localparam logic [7:0] A_MATCH = 8'h10, A_RELOAD = 8'h20, A_EVCFG = 8'h30;
   localparam logic [7:0] A_SETM = 8'h40, A_CLRM = 8'h50;

   // pre, period N, duty match D, inverted, conflict rule
   localparam int NVEC = 7;
   localparam int VEC [NVEC][5] = '{
      '{0, 10, 3, 0, 1},
      '{1,  8, 5, 0, 1},
      '{0,  6, 2, 1, 2},
      '{2,  5, 4, 0, 1},
      '{0,  7, 6, 1, 2},
      '{0,  4, 0, 0, 1},
      '{3,  6, 9, 0, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   evpwm_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // period on event 0 (match 0), duty on event 1 (match 1), output 0
   task automatic setup_pwm(input int pre, input int n, input int d, input int inv, input int rule);
      do_reset();
      wr(A_MATCH, 32'(n-1));  wr(A_RELOAD, 32'(n-1));
      wr(A_MATCH + 8'd1, 32'(d)); wr(A_RELOAD + 8'd1, 32'(d));
      wr(A_EVCFG, 32'h1000); wr(A_EVCFG + 8'd1, 32'h1001);
      wr(A_LIMIT, 32'h1);
      wr(A_SETM, inv != 0 ? 32'h2 : 32'h1);
      wr(A_CLRM, inv != 0 ? 32'h1 : 32'h2);
      wr(A_CONF, 32'(rule));
      wr(A_CTRL, 32'(pre) << 5);
   endtask

   task automatic measure(input int bit_i, input int len, output int hi, output int rises);
      logic prev;
      repeat (2*len) @(negedge clk);
      prev = pwm_out[bit_i];
      hi = 0; rises = 0;
      for (int k = 0; k < 4*len; k++) begin
         @(negedge clk);
         if (pwm_out[bit_i]) hi++;
         if (pwm_out[bit_i] && !prev) rises++;
         prev = pwm_out[bit_i];
      end
   endtask

   // conflict scenario on output 2: period 4 on event 0, event 1 at count 1
   task automatic conf_case(input int rule, input logic [31:0] setm, input int exp_hi);
      int hi, rs;
      do_reset();
      wr(A_MATCH, 32'd3); wr(A_RELOAD, 32'd3);
      wr(A_MATCH + 8'd1, 32'd1); wr(A_RELOAD + 8'd1, 32'd1);
      wr(A_EVCFG, 32'h1000); wr(A_EVCFG + 8'd1, 32'h1001);
      wr(A_LIMIT, 32'h1);
      wr(A_SETM + 8'd2, setm); wr(A_CLRM + 8'd2, 32'h1);
      wr(A_CONF, 32'(rule) << 4);
      wr(A_CTRL, 32'h0);
      measure(2, 4, hi, rs);
      check(hi == exp_hi, $sformatf("R5 rule %0d high count", rule), hi, exp_hi);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, c1, c2;
      logic [15:0] o1;
      int hi, rs, per, ht, exp_rs;

      @(negedge clk);
      do_reset();
      // R1 reset state
      check(pwm_out == 16'h0, "R1 outputs after reset", pwm_out, 0);
      rd(A_CTRL, d);  check(d == 32'h4, "R1 control after reset", d, 4);
      rd(A_COUNT, c1);
      repeat (5) @(negedge clk);
      rd(A_COUNT, d); check(d == 0 && c1 == 0, "R1 counter zero and frozen", d, 0);
      rd(A_MATCH + 8'd4, d); check(d == 0, "R1 match reset", d, 0);
      rd(A_LIMIT, d); check(d == 0, "R1 limit reset", d, 0);

      // R10 readback of writable words
      wr(A_SETM + 8'd3, 32'hA5A5);
      rd(A_SETM + 8'd3, d); check(d == 32'hA5A5, "R10 set mask readback", d, 32'hA5A5);
      wr(A_EVCFG + 8'd5, 32'h100F);
      rd(A_EVCFG + 8'd5, d); check(d == 32'h100F, "R10 event config readback", d, 32'h100F);

      // table-driven period / duty / polarity / prescaler runs (R3 R6 R9)
      for (int v = 0; v < NVEC; v++) begin
         setup_pwm(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
         per = VEC[v][1] * (VEC[v][0] + 1);
         if (VEC[v][2] >= VEC[v][1] - 1) ht = (VEC[v][3] != 0) ? 0 : VEC[v][1];
         else ht = (VEC[v][3] != 0) ? VEC[v][1] - 1 - VEC[v][2] : VEC[v][2] + 1;
         exp_rs = (ht > 0 && ht < VEC[v][1]) ? 4 : 0;
         measure(0, per, hi, rs);
         check(hi == 4 * ht * (VEC[v][0] + 1), $sformatf("R6 R9 vector %0d high clocks", v),
               hi, 4 * ht * (VEC[v][0] + 1));
         check(rs == exp_rs, $sformatf("R3 vector %0d rising edges", v), rs, exp_rs);
      end

      // R7 reload takes effect only at the boundary or while halted
      setup_pwm(0, 10, 3, 0, 1);
      wr(A_RELOAD, 32'd5);
      rd(A_MATCH, d); check(d == 9, "R7 match unchanged mid-period", d, 9);
      repeat (25) @(negedge clk);
      rd(A_MATCH, d); check(d == 5, "R7 match reloaded at boundary", d, 5);

      // R8 halt freezes counter and outputs
      wr(A_CTRL, 32'h4);
      o1 = pwm_out;
      rd(A_COUNT, c1);
      repeat (10) @(negedge clk);
      rd(A_COUNT, c2);
      check(c1 == c2, "R8 counter frozen by halt", c2, c1);
      check(pwm_out == o1, "R8 outputs frozen by halt", pwm_out, o1);
      wr(A_RELOAD + 8'd1, 32'd7);
      @(negedge clk);
      rd(A_MATCH + 8'd1, d); check(d == 7, "R7 match follows reload while halted", d, 7);

      // R2 disabled or non-match combine events never fire
      do_reset();
      wr(A_MATCH, 32'd3); wr(A_RELOAD, 32'd3);
      wr(A_MATCH + 8'd1, 32'd1); wr(A_RELOAD + 8'd1, 32'd1);
      wr(A_EVCFG, 32'h1000); wr(A_LIMIT, 32'h1);
      wr(A_EVCFG + 8'd1, 32'h0);    wr(A_SETM + 8'd1, 32'h2);
      wr(A_EVCFG + 8'd2, 32'h2001); wr(A_SETM + 8'd2, 32'h4);
      wr(A_EVCFG + 8'd3, 32'h1001); wr(A_SETM + 8'd3, 32'h8);
      wr(A_CTRL, 32'h0);
      repeat (20) @(negedge clk);
      check(pwm_out[1] == 1'b0, "R2 zero config never fires", pwm_out[1], 0);
      check(pwm_out[2] == 1'b0, "R2 combine 2 never fires", pwm_out[2], 0);
      check(pwm_out[3] == 1'b1, "R2 match config fires", pwm_out[3], 1);

      // R5 conflict rules on output 2 (field bits 5:4)
      conf_case(0, 32'h3, 16);
      conf_case(1, 32'h1, 16);
      conf_case(2, 32'h3, 8);
      conf_case(3, 32'h1, 8);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule